// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block drives and samples one bank of up to 32 general-purpose lines, organised as four 8-bit ports. Software reaches it through a plain 32-bit register port: it chooses per line whether the line is driven, writes the value to drive, reads back the line levels, and arms each line to raise an interrupt on a falling edge, a rising edge or both. Each incoming pin goes through a two-flop synchronizer and then an edge detector. A selected edge sets a sticky pending bit, which software clears by writing a one to it. The single interrupt output is high while any pending bit is set.

The registers that hold one bit per line pack the four ports into one word. The registers that hold a 2-bit edge code per line pack them into two words. A build parameter picks between two port orderings of these packed words, so the same block serves either software layout. The number of implemented lines is a parameter. Bits that belong to lines that are not implemented read as zero and ignore writes.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0, `pinOe` is all 0 (every line an input) and `irqOut` is 0.
- R2: The direction register at byte address 0x08 holds one bit per line: 1 makes the line an output (its `pinOe` bit goes high) and 0 makes it an input. `pinOut` always carries the stored output value of each line.
- R3: The data register at 0x0C returns the stored output value for output lines and the synchronized pin level for input lines. A pin change shows in the read at the second rising clock edge after the change. Writes update the stored output value of every implemented line.
- R4: The one-bit-per-line registers (0x08, 0x0C, 0x10) use this layout. With the reversed-port parameter clear, line n sits at bit 8*(3 - n/8) + (n mod 8), so port A is in the top byte. With the parameter set, line n sits at bit n.
- R5: The edge-code words at 0x14 (bits 31:0) and 0x18 (bits 63:32) form one 64-bit field space. Line n's 2-bit code sits at position 2n when the parameter is set, and at 2*(8*((n/8) XOR 1) + (n mod 8)) when it is clear.
- R6: Code 0 arms no edge, 1 arms the falling edge, 2 the rising edge and 3 both edges. An armed edge sets the line's pending bit at the third rising clock edge after the pin change. An edge that is not armed sets nothing.
- R7: The pending register at 0x10 reads one bit per line. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R8: When a clearing write and a newly detected armed edge reach the same pending bit in the same cycle, the bit stays set.
- R9: `irqOut` is high exactly when at least one pending bit is set. Writing code 0 for a line stops new pending bits for it but keeps one that is already set.
- R10: For lines at or above `NUM_LINES`, every register bit and edge-code field reads 0 and writes to it have no effect.
- R11: Any address other than 0x08, 0x0C, 0x10, 0x14 and 0x18 reads 0 and ignores writes. This includes 0x00 and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| pinIn | input | NUM_LINES | Asynchronous pin levels |
| pinOut | output | NUM_LINES | Stored output value per line |
| pinOe | output | NUM_LINES | Output enable per line (direction bit) |
| irqOut | output | 1 | High while any pending bit is set |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as a newly detected edge on the same line. The bench first makes a line pending on its rising edge. It then drops the pin and times the clearing write to arrive exactly three rising edges later, when the falling edge is recognised. It also checks the cycle just before the pending bit appears, so an off-by-one in the synchronizer depth is caught. A second instance built with the reversed port order and only 20 lines sees the same writes, which exercises both layouts and the dropping of bits for lines that are not implemented.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W = 32;

  // word indices (byte address >> 2)
  localparam int WORD_DIR     = 2;
  localparam int WORD_DATA    = 3;
  localparam int WORD_STAT    = 4;
  localparam int WORD_MODE_LO = 5;
  localparam int WORD_MODE_HI = 6;

  // 2-bit edge codes: bit0 arms falling, bit1 arms rising
  localparam logic [1:0] EDGE_OFF  = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_RISE = 2'd2;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic wrStat;
    logic wrModeLo;
    logic wrModeHi;
  } regStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DATA,
    SEL_STAT,
    SEL_MODE_LO,
    SEL_MODE_HI
  } readSel_t;

  // bit of a line inside a one-bit-per-line word
  function automatic logic [4:0] lineBit(input int line, input bit rev);
    int pos;
    pos = rev ? line : (8 * (3 - line / 8) + line % 8);
    return pos[4:0];
  endfunction

  // position of a line's 2-bit code inside the 64-bit mode space
  function automatic logic [5:0] lineField(input int line, input bit rev);
    int pos;
    pos = rev ? 2 * line : 2 * (8 * ((line / 8) ^ 1) + line % 8);
    return pos[5:0];
  endfunction

endpackage

// File: rtl/gpio_line_cell.sv
module gpio_line_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pinAsync,
  input  logic [1:0] edgeCode,
  input  logic       clrReq,
  output logic       lvlSync,
  output logic       pending
);

  logic sync1Q, sync2Q, prevQ, statQ;
  logic riseHit, fallHit, edgeHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1Q <= 1'b0;
      sync2Q <= 1'b0;
      prevQ  <= 1'b0;
    end else begin
      sync1Q <= pinAsync;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  assign riseHit = sync2Q & ~prevQ;
  assign fallHit = prevQ & ~sync2Q;
  assign edgeHit = (riseHit & edgeCode[1]) | (fallHit & edgeCode[0]);

  // a fresh edge outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) statQ <= 1'b0;
    else        statQ <= (statQ & ~clrReq) | edgeHit;
  end

  assign lvlSync = sync2Q;
  assign pending = statQ;

  // R6: a pending bit appears only when the previous cycle had an armed code
  a_r6_set_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(edgeCode) != 2'b00);

  // R6: a pending bit appears only after the synchronized level moved
  a_r6_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(sync2Q) != $past(prevQ));

  // R7: a pending bit leaves only through a clearing write
  a_r7_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(clrReq));

  // R8: simultaneous edge and clear leaves the bit set
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clrReq && edgeHit) |-> pending);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe,
  output readSel_t          rdSel
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    rdSel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        WIDX_W'(WORD_DIR):     rdSel = SEL_DIR;
        WIDX_W'(WORD_DATA):    rdSel = SEL_DATA;
        WIDX_W'(WORD_STAT):    rdSel = SEL_STAT;
        WIDX_W'(WORD_MODE_LO): rdSel = SEL_MODE_LO;
        WIDX_W'(WORD_MODE_HI): rdSel = SEL_MODE_HI;
        default:               rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      case (rdSel)
        SEL_DIR:     strobe.wrDir    = 1'b1;
        SEL_DATA:    strobe.wrData   = 1'b1;
        SEL_STAT:    strobe.wrStat   = 1'b1;
        SEL_MODE_LO: strobe.wrModeLo = 1'b1;
        SEL_MODE_HI: strobe.wrModeHi = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

  // R11: at most one register is written per access
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  // R11: a misaligned address selects nothing
  a_r11_misaligned_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr[1:0] != 2'b00) |-> (rdSel == SEL_NONE && strobe == '0));

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter bit REV_PORTS = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  regStrobe_t           strobe,
  input  readSel_t             rdSel,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [REG_W-1:0]     rdData,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);

  localparam int WIDE_W = 2 * REG_W;

  logic [NUM_LINES-1:0]      dirQ, outQ, dirNext, outNext;
  logic [NUM_LINES-1:0]      lvlSync, pending, clrLine, codeWe;
  logic [NUM_LINES-1:0][1:0] codeQ, codeNext;
  logic [WIDE_W-1:0]         wideWr, modeWide;
  logic [REG_W-1:0]          dirWord, dataWord, statWord;

  assign wideWr = {wrData, wrData};

  // unpack the bus word into per-line values
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      dirNext[i]  = wrData[lineBit(i, REV_PORTS)];
      outNext[i]  = wrData[lineBit(i, REV_PORTS)];
      clrLine[i]  = strobe.wrStat & wrData[lineBit(i, REV_PORTS)];
      codeNext[i] = wideWr[lineField(i, REV_PORTS) +: 2];
      codeWe[i]   = lineField(i, REV_PORTS) >= 6'(REG_W) ? strobe.wrModeHi
                                                         : strobe.wrModeLo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirQ  <= '0;
      outQ  <= '0;
      codeQ <= '0;
    end else begin
      if (strobe.wrDir)  dirQ <= dirNext;
      if (strobe.wrData) outQ <= outNext;
      for (int i = 0; i < NUM_LINES; i++)
        if (codeWe[i]) codeQ[i] <= codeNext[i];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    gpio_line_cell cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pinAsync (pinIn[g]),
      .edgeCode (codeQ[g]),
      .clrReq   (clrLine[g]),
      .lvlSync  (lvlSync[g]),
      .pending  (pending[g])
    );
  end

  // pack per-line state back into bus words
  always_comb begin
    dirWord  = '0;
    dataWord = '0;
    statWord = '0;
    modeWide = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      dirWord[lineBit(i, REV_PORTS)]  = dirQ[i];
      dataWord[lineBit(i, REV_PORTS)] = dirQ[i] ? outQ[i] : lvlSync[i];
      statWord[lineBit(i, REV_PORTS)] = pending[i];
      modeWide[lineField(i, REV_PORTS) +: 2] = codeQ[i];
    end
  end

  always_comb begin
    case (rdSel)
      SEL_DIR:     rdData = dirWord;
      SEL_DATA:    rdData = dataWord;
      SEL_STAT:    rdData = statWord;
      SEL_MODE_LO: rdData = modeWide[REG_W-1:0];
      SEL_MODE_HI: rdData = modeWide[WIDE_W-1:REG_W];
      default:     rdData = '0;
    endcase
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ;
  assign irqOut = |pending;

  // R9: the interrupt only drops after a clearing write
  a_r9_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqOut) |-> $past(strobe.wrStat));

  // R2: enables change only on a direction write
  a_r2_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.wrDir) |-> $stable(pinOe));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter bit REV_PORTS = 1'b0,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);

  regStrobe_t strobe;
  readSel_t   rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_bank_datapath #(.NUM_LINES(NUM_LINES), .REV_PORTS(REV_PORTS)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (regWrData),
    .pinIn  (pinIn),
    .rdData (regRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

endmodule

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;

  localparam logic [4:0] A_SEL  = 5'h00;
  localparam logic [4:0] A_DIR  = 5'h08;
  localparam logic [4:0] A_DATA = 5'h0C;
  localparam logic [4:0] A_STAT = 5'h10;
  localparam logic [4:0] A_MLO  = 5'h14;
  localparam logic [4:0] A_MHI  = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] pinInN = '0;
  logic [19:0] pinInR = '0;
  logic [31:0] rdN, outN, oeN;
  logic [31:0] rdR;
  logic [19:0] outR, oeR;
  logic        irqN, irqR;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int          kindQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  gpio_edge_bank #(.NUM_LINES(32), .REV_PORTS(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdN), .pinIn(pinInN),
    .pinOut(outN), .pinOe(oeN), .irqOut(irqN));

  gpio_edge_bank #(.NUM_LINES(20), .REV_PORTS(1'b1)) dutRev_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdR), .pinIn(pinInR),
    .pinOut(outR), .pinOe(oeR), .irqOut(irqR));

  // layouts from R4 / R5 (normal order)
  function automatic int nb(input int n);
    return 8 * (3 - n / 8) + n % 8;
  endfunction
  function automatic int nf(input int n);
    return 2 * (8 * ((n / 8) ^ 1) + n % 8);
  endfunction
  function automatic logic [31:0] bitAt(input int p);
    return 32'h1 << p;
  endfunction

  function automatic logic [31:0] observe(input int kind);
    case (kind)
      0: return rdN;
      1: return rdR;
      2: return {31'b0, irqN};
      3: return {31'b0, irqR};
      4: return oeN;
      5: return outN;
      6: return {12'b0, oeR};
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // driver: present a read address and queue the expected value
  task automatic expectRead(input int kind, input logic [4:0] a,
                            input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    kindQ.push_back(kind); expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic expectPort(input int kind, input logic [31:0] e, input string tag);
    kindQ.push_back(kind); expQ.push_back(e); tagQ.push_back(tag);
  endtask

  // monitor: compare queued items away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (kindQ.size() > 0) begin
        int k;
        logic [31:0] e, act;
        string t;
        k = kindQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
        act = observe(k);
        testsRun++;
        if (act !== e) begin
          testsFailed++;
          $display("FAIL %s: actual %08h expected %08h", t, act, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;

    // R1 reset state
    expectRead(0, A_DIR,  32'h0, "R1 dir");
    expectRead(0, A_DATA, 32'h0, "R1 data");
    expectRead(0, A_STAT, 32'h0, "R1 stat");
    expectRead(0, A_MLO,  32'h0, "R1 mode lo");
    expectRead(0, A_MHI,  32'h0, "R1 mode hi");
    expectPort(2, 32'h0, "R1 irq");
    expectPort(4, 32'h0, "R1 oe");

    // R2 line 3 as output, R10 rev instance drops bit 27
    wr(A_DIR, bitAt(nb(3)));
    expectRead(0, A_DIR, bitAt(27), "R2 dir readback");
    expectPort(4, bitAt(3), "R2 oe line3");
    expectRead(1, A_DIR, 32'h0, "R10 rev dir bit27 dropped");
    wr(A_DATA, 32'hFFFF_FFFF);
    expectPort(5, 32'hFFFF_FFFF, "R2 pinOut");
    expectRead(0, A_DATA, bitAt(27), "R3 output line readback");

    // R3 input level after two edges
    pinInN[10] = 1'b1;
    expectRead(0, A_DATA, bitAt(27), "R3 not yet synced");
    expectRead(0, A_DATA, bitAt(27) | bitAt(nb(10)), "R3 synced level");

    // R4 packing in both orders
    wr(A_DIR, 32'h000F_0001);
    expectPort(4, bitAt(24) | (32'hF << 8), "R4 normal oe");
    expectPort(6, 32'h000F_0001, "R4 reversed oe");
    expectRead(1, A_DIR, 32'h000F_0001, "R4 reversed dir");
    wr(A_DIR, 32'h0);

    // R5 code fields: line5 rise, line12 both, line20 fall
    wr(A_MLO, (32'd2 << nf(5)) | (32'd3 << nf(12)));
    wr(A_MHI, 32'd1 << (nf(20) - 32));
    expectRead(0, A_MLO, (32'd2 << 26) | (32'd3 << 8), "R5 mode lo");
    expectRead(0, A_MHI, 32'd1 << 24, "R5 mode hi");
    expectRead(1, A_MLO, (32'd2 << 26) | (32'd3 << 8), "R5 rev mode lo");
    expectRead(1, A_MHI, 32'h0, "R10 rev line28 field dropped");

    // R6 rising edge timing on line 5
    pinInN[5] = 1'b1;
    tick(1);
    expectRead(0, A_STAT, 32'h0, "R6 not before third edge");
    expectRead(0, A_STAT, bitAt(nb(5)), "R6 rising sets");
    expectPort(2, 32'h1, "R9 irq high");
    // line 20 rising is not armed, falling is
    pinInN[20] = 1'b1;
    tick(2);
    expectRead(0, A_STAT, bitAt(nb(5)), "R6 unarmed edge ignored");
    pinInN[20] = 1'b0;
    tick(2);
    expectRead(0, A_STAT, bitAt(nb(5)) | bitAt(nb(20)), "R6 falling sets");

    // R7 write-one-to-clear
    wr(A_STAT, 32'h0);
    expectRead(0, A_STAT, bitAt(29) | bitAt(12), "R7 zero write keeps");
    wr(A_STAT, bitAt(29));
    expectRead(0, A_STAT, bitAt(12), "R7 one clears");

    // R9 code 0 keeps pending bit, blocks new ones
    wr(A_MHI, 32'h0);
    expectRead(0, A_STAT, bitAt(12), "R9 pending kept");
    pinInN[20] = 1'b1; tick(3);
    pinInN[20] = 1'b0; tick(3);
    expectRead(0, A_STAT, bitAt(12), "R9 disabled line quiet");
    wr(A_STAT, bitAt(12));
    expectRead(0, A_STAT, 32'h0, "R7 cleared");
    expectPort(2, 32'h0, "R9 irq low");

    // R8 edge and clear in the same cycle on line 12
    pinInN[12] = 1'b1;
    tick(2);
    expectRead(0, A_STAT, bitAt(nb(12)), "R6 both rise");
    pinInN[12] = 1'b0;
    tick(1);
    wr(A_STAT, bitAt(nb(12)));
    expectRead(0, A_STAT, bitAt(nb(12)), "R8 edge wins");
    wr(A_STAT, bitAt(nb(12)));
    expectRead(0, A_STAT, 32'h0, "R8 later clear");

    // reversed instance edges: line13 rise, line4 both
    pinInR[13] = 1'b1;
    tick(2);
    expectRead(1, A_STAT, bitAt(13), "R4 rev stat bit13");
    expectPort(3, 32'h1, "R9 rev irq");
    pinInR[4] = 1'b1;
    tick(2);
    expectRead(1, A_STAT, bitAt(13) | bitAt(4), "R4 rev stat bit4");
    expectRead(1, A_DATA, bitAt(13) | bitAt(4), "R3 rev data");
    wr(A_STAT, 32'hFFFF_FFFF);
    expectRead(1, A_STAT, 32'h0, "R7 rev clear all");
    expectPort(3, 32'h0, "R9 rev irq low");

    // R11 unmapped and misaligned addresses
    expectRead(0, A_SEL, 32'h0, "R11 addr 0x00");
    wr(5'h0A, 32'hFFFF_FFFF);
    wr(A_SEL, 32'hFFFF_FFFF);
    expectRead(0, A_DIR, 32'h0, "R11 misaligned write ignored");
    expectRead(0, 5'h09, 32'h0, "R11 misaligned read");
    expectRead(0, 5'h1C, 32'h0, "R11 addr 0x1C");

    tick(3);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule